// File: doc/BRIEF.md
# Trace Buffer Stall Controller

This block sits between a trace buffer and the core that produces trace data. It watches how much free space the buffer has and raises a registered stall request towards the core when that space runs low, so trace data is not lost. Software programs when stalling should happen through a 64-bit control word. The word holds a 4-bit invasiveness level that picks the stall threshold, an enable that lets the block stall the core at all, and a hard no-overflow enable that forces stalling early enough that the buffer can never be overrun.

The control word only accepts writes while the trace unit reports that it is idle. Writes at any other time are dropped. Each cycle the block also judges the number of entries the trace source wants to push. A push that does not fit into the current free space is refused and flagged one cycle later on an error output. A status output stays low after reset until the first accepted write, which tells software that the register has not been set up yet. The level field can keep fewer than four bits: a parameter sets how many of its upper bits are kept, and the unkept low bits store and read as zero.

Top module: `trace_stall_ctl`

## Requirements
- R1: After reset `cfg_rdata` is zero, and `stall_core`, `ovf_err` and `cfg_valid` are all low.
- R2: In the control word, the level sits in bits [3:0], the stall enable in bit 8 and the no-overflow enable in bit 13. Every other bit of `cfg_rdata` reads as zero whatever was written to it.
- R3: A write with `cfg_we` high while `trace_idle` is low leaves the control word unchanged.
- R4: Only the upper LVL_KEEP bits of the level are kept. With LVL_KEEP = 2, written bits [1:0] store and read as zero.
- R5: While both the stall enable and the no-overflow enable are 0, `stall_core` is never asserted.
- R6: With the stall enable at 1, `stall_core` is high in the cycle after free space is sampled below (L+1)·DEPTH/16, where L is the kept level. It is low in the cycle after free space is sampled at or above that threshold, unless R7 holds it high.
- R7: With the no-overflow enable at 1, `stall_core` is high in the cycle after free space is sampled below 2·MAX_PUSH, whatever the stall enable and level are.
- R8: `push_ok` is high exactly when `push_req` is non-zero and not larger than `free_space`. If `push_req` exceeds `free_space`, `ovf_err` is high in the following cycle.
- R9: `cfg_valid` rises in the cycle after the first accepted write and then stays high until reset.
- R10: In no-overflow mode, a source that pushes MAX_PUSH entries in every cycle where `stall_core` is low never causes `ovf_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 64 | Control word write data |
| cfg_rdata | output | 64 | Current control word, reserved bits zero |
| trace_idle | input | 1 | Trace unit is idle; writes are accepted only then |
| free_space | input | $clog2(DEPTH+1) | Free entries in the trace buffer |
| push_req | input | $clog2(MAX_PUSH+1) | Entries the source wants to push this cycle |
| push_ok | output | 1 | The requested push fits and is accepted |
| stall_core | output | 1 | Registered stall request to the core |
| ovf_err | output | 1 | A push that did not fit was requested last cycle |
| cfg_valid | output | 1 | Control word has been written since reset |

## Verification
The bench builds the block with DEPTH = 64, MAX_PUSH = 4 and LVL_KEEP = 2. With these values each level step is four entries, so a level of 3 and a level of 0 both give a threshold of 4, a level of 15 falls back to the threshold of a level of 12, and the no-overflow guard sits at 8 entries. This lets the table test both sides of every threshold and show that the unkept level bits are truncated. A closed-loop run with a modelled buffer fills the buffer at the full push rate in no-overflow mode, which shows that the guard band covers the one-cycle latency of the stall.

// File: rtl/trace_stall_pkg.sv
// Package: shared control-word layout and configuration type for the
// trace buffer stall controller. Bit positions are fixed because software
// decodes them; all other bits of the word are reserved and read as zero.
package trace_stall_pkg;

    localparam int CFG_W      = 64;
    localparam int LVL_LSB    = 0;
    localparam int LVL_W      = 4;
    localparam int STALL_BIT  = 8;
    localparam int GUARD_BIT  = 13;

    typedef struct packed {
        logic             guard_en;  // hard no-overflow mode
        logic             stall_en;  // core may be stalled
        logic [LVL_W-1:0] level;     // invasiveness level, kept bits only
    } stall_cfg_t;

    // Build the software-visible word from the stored fields.
    function automatic logic [CFG_W-1:0] cfg_to_word(input stall_cfg_t c);
        logic [CFG_W-1:0] w;
        w = '0;
        w[LVL_LSB +: LVL_W] = c.level;
        w[STALL_BIT]        = c.stall_en;
        w[GUARD_BIT]        = c.guard_en;
        return w;
    endfunction

endpackage

// File: rtl/stall_cfg_reg.sv
// Module: stall_cfg_reg
// Holds the stall control fields. It accepts a write only while the trace
// unit is idle and drops the level bits that are not kept. It also records
// whether any write has been accepted since reset.
// Assumes: LVL_KEEP in 0..4; reset is synchronous and active low.
module stall_cfg_reg
    import trace_stall_pkg::*;
#(
    parameter int LVL_KEEP = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    input  logic             idle,
    output stall_cfg_t       cfg,
    output logic             programmed
);

    localparam logic [LVL_W-1:0] LVL_MASK = LVL_W'(4'hF << (LVL_W - LVL_KEEP));

    logic accept;

    // Purpose: a write counts only while the trace unit is idle.
    always_comb accept = we && idle;

    // Purpose: field storage, reset to zero, with unkept level bits dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (accept) begin
            cfg.level    <= wdata[LVL_LSB +: LVL_W] & LVL_MASK;
            cfg.stall_en <= wdata[STALL_BIT];
            cfg.guard_en <= wdata[GUARD_BIT];
        end
    end

    // Purpose: sticky flag marking that software has set up the register.
    always_ff @(posedge clk) begin
        if (!rst_n)      programmed <= 1'b0;
        else if (accept) programmed <= 1'b1;
    end

    // R3: a write while busy must not touch the fields
    a_r3_busy_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !idle) |=> $stable(cfg));

    // R9: once programmed, the flag holds until reset
    a_r9_valid_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        programmed |=> programmed);

    // R9: the flag rises only through an accepted write
    a_r9_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(programmed) |-> $past(we && idle));

endmodule

// File: rtl/stall_thresh.sv
// Module: stall_thresh
// Compares free space with the level threshold (L+1)*DEPTH/16 and with the
// no-overflow guard of 2*MAX_PUSH. The guard covers the push one cycle can
// add plus the push that slips through during the registered stall latency.
// Assumes: DEPTH is a multiple of 16; CNT_W is wide enough to hold DEPTH.
module stall_thresh
    import trace_stall_pkg::*;
#(
    parameter int DEPTH    = 64,
    parameter int MAX_PUSH = 4,
    parameter int LVL_KEEP = 2,
    parameter int CNT_W    = $clog2(DEPTH + 1)
) (
    input  logic [LVL_W-1:0] level,
    input  logic [CNT_W-1:0] free,
    output logic             below_level,
    output logic             below_guard
);

    localparam int STEP    = DEPTH / 16;
    localparam int GUARD   = 2 * MAX_PUSH;
    localparam int TW      = CNT_W + 1;

    logic [TW-1:0] thresh;

    generate
        if (LVL_KEEP == 0) begin : g_fixed
            // Purpose: with no kept level bits the threshold is one step.
            always_comb thresh = TW'(STEP);
        end else if ((STEP & (STEP - 1)) == 0) begin : g_shift
            localparam int SH = $clog2(STEP);
            // Purpose: power-of-two step, so the threshold is a shift.
            always_comb thresh = (TW'(level) + TW'(1)) << SH;
        end else begin : g_mult
            // Purpose: general step, so the threshold is a product.
            always_comb thresh = (TW'(level) + TW'(1)) * TW'(STEP);
        end
    endgenerate

    // Purpose: raw comparisons that the stall register samples.
    always_comb begin
        below_level = TW'(free) < thresh;
        below_guard = TW'(free) < TW'(GUARD);
    end

endmodule

// File: rtl/stall_gen.sv
// Module: stall_gen
// Registers the stall request from the threshold comparisons and the two
// enables. It also judges each push request against the free space and
// flags a push that would overrun the buffer one cycle later.
// Assumes: PUSH_W <= CNT_W.
module stall_gen #(
    parameter int CNT_W  = 7,
    parameter int PUSH_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stall_en,
    input  logic              guard_en,
    input  logic              below_level,
    input  logic              below_guard,
    input  logic [CNT_W-1:0]  free,
    input  logic [PUSH_W-1:0] push_req,
    output logic              stall,
    output logic              push_ok,
    output logic              ovf_err
);

    logic too_big;

    // Purpose: decide whether this cycle's push fits in the buffer.
    always_comb begin
        too_big = CNT_W'(push_req) > free;
        push_ok = (push_req != '0) && !too_big;
    end

    // Purpose: registered stall request; either enable may raise it.
    always_ff @(posedge clk) begin
        if (!rst_n) stall <= 1'b0;
        else        stall <= (stall_en && below_level) || (guard_en && below_guard);
    end

    // Purpose: one-cycle flag for a push that did not fit.
    always_ff @(posedge clk) begin
        if (!rst_n) ovf_err <= 1'b0;
        else        ovf_err <= too_big;
    end

    // R5: with both enables off the core is never stalled
    a_r5_no_stall_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall_en && !guard_en) |=> !stall);

    // R6: below the level threshold with stalling enabled -> stall next cycle
    a_r6_level_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_en && below_level) |=> stall);

    // R7: below the guard in no-overflow mode -> stall next cycle
    a_r7_guard_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (guard_en && below_guard) |=> stall);

    // R8: an oversized push is flagged in the next cycle
    a_r8_ovf_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (CNT_W'(push_req) > free) |=> ovf_err);

    // R8: an accepted push always fits
    always_comb begin
        if (rst_n && push_ok)
            a_r8_push_fits: assert (CNT_W'(push_req) <= free);
    end

endmodule

// File: rtl/trace_stall_ctl.sv
// Module: trace_stall_ctl (top)
// Trace buffer stall controller: holds the control word, derives the stall
// threshold and drives a registered stall request plus the push acceptance.
// Assumes: DEPTH is a multiple of 16, MAX_PUSH <= DEPTH, and software
// programs the word while the trace unit is idle and before tracing starts.
module trace_stall_ctl
    import trace_stall_pkg::*;
#(
    parameter int DEPTH    = 64,
    parameter int MAX_PUSH = 4,
    parameter int LVL_KEEP = 2,
    localparam int CNT_W   = $clog2(DEPTH + 1),
    localparam int PUSH_W  = $clog2(MAX_PUSH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [63:0]       cfg_wdata,
    output logic [63:0]       cfg_rdata,
    input  logic              trace_idle,
    input  logic [CNT_W-1:0]  free_space,
    input  logic [PUSH_W-1:0] push_req,
    output logic              push_ok,
    output logic              stall_core,
    output logic              ovf_err,
    output logic              cfg_valid
);

    stall_cfg_t cfg;
    logic       below_level;
    logic       below_guard;

    stall_cfg_reg #(.LVL_KEEP(LVL_KEEP)) u_reg (
        .clk        (clk),
        .rst_n      (rst_n),
        .we         (cfg_we),
        .wdata      (cfg_wdata),
        .idle       (trace_idle),
        .cfg        (cfg),
        .programmed (cfg_valid)
    );

    stall_thresh #(
        .DEPTH    (DEPTH),
        .MAX_PUSH (MAX_PUSH),
        .LVL_KEEP (LVL_KEEP),
        .CNT_W    (CNT_W)
    ) u_thresh (
        .level       (cfg.level),
        .free        (free_space),
        .below_level (below_level),
        .below_guard (below_guard)
    );

    stall_gen #(.CNT_W(CNT_W), .PUSH_W(PUSH_W)) u_gen (
        .clk         (clk),
        .rst_n       (rst_n),
        .stall_en    (cfg.stall_en),
        .guard_en    (cfg.guard_en),
        .below_level (below_level),
        .below_guard (below_guard),
        .free        (free_space),
        .push_req    (push_req),
        .stall       (stall_core),
        .push_ok     (push_ok),
        .ovf_err     (ovf_err)
    );

    // Purpose: software view of the word; reserved bits are forced to zero.
    always_comb cfg_rdata = cfg_to_word(cfg);

    // R2: reserved bits always read as zero
    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata & ~((64'hF << LVL_LSB) | (64'h1 << STALL_BIT) | (64'h1 << GUARD_BIT))) == 64'h0);

    // R1: after reset the stall and error outputs are low
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!stall_core && !ovf_err && !cfg_valid));

endmodule

// File: tb/trace_stall_ctl_test.sv
// Bench: table-driven threshold vectors, then directed tests for reset,
// register rules, push acceptance and a closed-loop no-overflow run.
module trace_stall_ctl_test;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 64;
    localparam int MAX_PUSH   = 4;
    localparam int LVL_KEEP   = 2;
    localparam int CNT_W      = $clog2(DEPTH + 1);
    localparam int PUSH_W     = $clog2(MAX_PUSH + 1);
    localparam int NVEC       = 17;

    // vector: level[13:10] stall_en[9] guard_en[8] free[7:1] expected_stall[0]
    localparam logic [13:0] VEC [NVEC] = '{
        {4'd0,  1'b0, 1'b0, 7'd0,  1'b0},
        {4'd0,  1'b1, 1'b0, 7'd3,  1'b1},
        {4'd0,  1'b1, 1'b0, 7'd4,  1'b0},
        {4'd4,  1'b1, 1'b0, 7'd19, 1'b1},
        {4'd4,  1'b1, 1'b0, 7'd20, 1'b0},
        {4'd8,  1'b1, 1'b0, 7'd35, 1'b1},
        {4'd8,  1'b1, 1'b0, 7'd36, 1'b0},
        {4'd12, 1'b1, 1'b0, 7'd51, 1'b1},
        {4'd12, 1'b1, 1'b0, 7'd52, 1'b0},
        {4'd15, 1'b1, 1'b0, 7'd51, 1'b1},
        {4'd15, 1'b1, 1'b0, 7'd52, 1'b0},
        {4'd3,  1'b1, 1'b0, 7'd3,  1'b1},
        {4'd3,  1'b1, 1'b0, 7'd4,  1'b0},
        {4'd0,  1'b0, 1'b1, 7'd7,  1'b1},
        {4'd0,  1'b0, 1'b1, 7'd8,  1'b0},
        {4'd15, 1'b0, 1'b1, 7'd20, 1'b0},
        {4'd15, 1'b0, 1'b0, 7'd0,  1'b0}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_we = 1'b0;
    logic [63:0]       cfg_wdata = '0;
    logic [63:0]       cfg_rdata;
    logic              trace_idle = 1'b1;
    logic [CNT_W-1:0]  free_space = CNT_W'(DEPTH);
    logic [PUSH_W-1:0] push_req = '0;
    logic              push_ok;
    logic              stall_core;
    logic              ovf_err;
    logic              cfg_valid;

    int n_vec = 0;
    int n_bad = 0;

    trace_stall_ctl #(.DEPTH(DEPTH), .MAX_PUSH(MAX_PUSH), .LVL_KEEP(LVL_KEEP)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .trace_idle (trace_idle),
        .free_space (free_space),
        .push_req   (push_req),
        .push_ok    (push_ok),
        .stall_core (stall_core),
        .ovf_err    (ovf_err),
        .cfg_valid  (cfg_valid)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] mk_word(input logic [3:0] lvl, input logic se, input logic ge);
        logic [63:0] w;
        w = '0;
        w[3:0] = lvl;
        w[8]   = se;
        w[13]  = ge;
        return w;
    endfunction

    // Write the word at a negedge; it is stored at the next posedge.
    task automatic write_cfg(input logic [63:0] w, input logic idle);
        @(negedge clk);
        cfg_we     = 1'b1;
        cfg_wdata  = w;
        trace_idle = idle;
        @(negedge clk);
        cfg_we     = 1'b0;
        trace_idle = 1'b1;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state, before release
        check("R1 rdata", cfg_rdata, 64'h0);
        check("R1 stall", {63'h0, stall_core}, 64'h0);
        check("R1 ovf", {63'h0, ovf_err}, 64'h0);
        check("R1 valid", {63'h0, cfg_valid}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: not yet programmed
        check("R9 valid before write", {63'h0, cfg_valid}, 64'h0);

        // Table walk: R4 R5 R6 R7 thresholds
        for (int i = 0; i < NVEC; i++) begin
            logic [13:0] v;
            v = VEC[i];
            @(negedge clk);
            cfg_we     = 1'b1;
            cfg_wdata  = mk_word(v[13:10], v[9], v[8]);
            free_space = CNT_W'(v[7:1]);
            @(negedge clk);
            cfg_we = 1'b0;
            @(negedge clk);
            check($sformatf("R5/R6/R7 vector %0d stall", i), {63'h0, stall_core}, {63'h0, v[0]});
        end

        // R9: set after first accepted write
        check("R9 valid after write", {63'h0, cfg_valid}, 64'h1);

        // R2 and R4: all-ones write keeps only the defined fields, level truncated
        write_cfg(64'hFFFF_FFFF_FFFF_FFFF, 1'b1);
        check("R2 R4 all-ones readback", cfg_rdata, 64'h0000_0000_0000_210C);
        write_cfg(64'h0000_0000_0000_0103, 1'b1);
        check("R4 low level bits dropped", cfg_rdata, 64'h0000_0000_0000_0100);

        // R3: busy write ignored, and stall behaviour unchanged
        write_cfg(mk_word(4'hC, 1'b1, 1'b1), 1'b0);
        check("R3 busy write ignored", cfg_rdata, 64'h0000_0000_0000_0100);
        free_space = CNT_W'(10);
        @(negedge clk);
        @(negedge clk);
        check("R3 R6 stall unchanged after busy write", {63'h0, stall_core}, 64'h0);

        // R6: deassert in the cycle after free rises to threshold
        free_space = CNT_W'(3);
        @(negedge clk);
        check("R6 stall rises", {63'h0, stall_core}, 64'h1);
        free_space = CNT_W'(4);
        @(negedge clk);
        check("R6 stall falls", {63'h0, stall_core}, 64'h0);

        // R8: push acceptance and overflow flag
        free_space = CNT_W'(5);
        push_req   = PUSH_W'(4);
        #1;
        check("R8 fitting push ok", {63'h0, push_ok}, 64'h1);
        push_req = PUSH_W'(0);
        #1;
        check("R8 empty push not ok", {63'h0, push_ok}, 64'h0);
        @(negedge clk);
        check("R8 no flag after fit", {63'h0, ovf_err}, 64'h0);
        push_req = PUSH_W'(6);
        #1;
        check("R8 oversized push refused", {63'h0, push_ok}, 64'h0);
        @(negedge clk);
        check("R8 oversized push flagged", {63'h0, ovf_err}, 64'h1);
        push_req = '0;
        @(negedge clk);
        check("R8 flag clears", {63'h0, ovf_err}, 64'h0);

        // R10: closed loop in no-overflow mode with a modelled buffer
        begin
            int free_m;
            int pushed;
            int err_seen;
            int stall_seen;
            free_m = DEPTH;
            pushed = 0;
            err_seen = 0;
            stall_seen = 0;
            write_cfg(mk_word(4'h0, 1'b0, 1'b1), 1'b1);
            for (int c = 0; c < 200; c++) begin
                @(negedge clk);
                if (ovf_err) err_seen++;
                if (stall_core) stall_seen++;
                free_m = free_m - pushed + ((c % 4 == 0) ? 1 : 0);
                if (free_m > DEPTH) free_m = DEPTH;
                free_space = CNT_W'(free_m);
                push_req   = stall_core ? '0 : PUSH_W'(MAX_PUSH);
                #1;
                pushed = push_ok ? int'(push_req) : 0;
            end
            @(negedge clk);
            push_req = '0;
            check("R10 no overflow flagged", 64'(err_seen), 64'h0);
            check("R10 guard stalled the source", {63'h0, stall_seen > 0}, 64'h1);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule